// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table held in memory. A requester presents the linear address with a valid/ready handshake. The walker first fetches a directory entry, selected by the top ten address bits and offset from a programmable directory base. It then fetches a table entry, selected by the middle ten bits and offset from the frame named in the directory entry. The final physical address is the frame from the table entry with the low twelve offset bits of the linear address appended unchanged. Pages are 4 KB.

Bit 0 of every entry is its present flag. If either fetched entry is not present, the walk stops and returns a fault that names the level at which it stopped. When the paging-enable input is low, a request is answered on the following cycle with the linear address passed straight through and no memory traffic. The walker accepts only one request at a time and serves it to completion before it accepts the next.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is low and right after it is released, req_ready is 1, resp_valid is 0 and mem_rd_en is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the walk has answered, and req_valid in that window starts no walk, issues no read and produces no response.
- R3: With paging enabled, the first read of a walk is at address {directory base frame, lin[31:22], 2'b00}, where the base frame is the 20-bit register value.
- R4: If the directory entry has bit 0 set, the second read is at address {directory entry[31:12], lin[21:12], 2'b00}.
- R5: If both entries have bit 0 set, the response has resp_fault 0, resp_fault_lvl 0 and resp_phys equal to {table entry[31:12], lin[11:0]}.
- R6: A directory entry with bit 0 clear ends the walk after that one read, with resp_fault 1 and resp_fault_lvl 2'd1.
- R7: A table entry with bit 0 clear ends the walk with resp_fault 1 and resp_fault_lvl 2'd2, after exactly two reads.
- R8: With paging_en low at acceptance, resp_valid is 1 in the very next cycle, with resp_phys equal to the accepted linear address and resp_fault 0. No read is issued.
- R9: A clock edge with base_we high loads base_wdata into the directory base frame. A walk uses the base held at its acceptance edge, even if the base is written while that walk is in progress.
- R10: Once mem_rd_en is raised, it stays high with mem_rd_addr unchanged until mem_rd_valid is sampled high, for any read latency of one cycle or more. mem_rd_data is taken in that same cycle.
- R11: resp_valid is high for exactly one cycle, and req_ready is 1 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| paging_en | input | 1 | 1 = translate through tables, 0 = pass the address through |
| base_we | input | 1 | Write strobe for the directory base frame |
| base_wdata | input | 20 | New directory base frame (address bits 31:12) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| mem_rd_en | output | 1 | Read outstanding toward memory |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data valid for the outstanding read |
| mem_rd_data | input | 32 | Entry word returned by memory |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_phys | output | 32 | Physical address (0 on a fault) |
| resp_fault | output | 1 | Walk stopped on an entry that is not present |
| resp_fault_lvl | output | 2 | 1 = directory level, 2 = table level, 0 = no fault |

## Verification
A corrupted walk state shows up at the memory port within one cycle. A read appears while req_ready is high, mem_rd_en drops before data arrives, or the address moves during a wait. Each of these is caught at the first wrong edge. A wrong index or base shows up as a mismatched read address on the first or second fetch, because the memory model compares every read against an address worked out from the requirements. A wrongly latched entry or fault level shows up in the single response cycle of that walk. An extra or missing state shows up as a response in the wrong cycle, or as a response with no matching scoreboard entry.

// File: rtl/pgwalk_pkg.sv
// Shared types and constants for the two-level page table walker.
// Assumes nothing beyond IEEE 1800-2017 package support.
package pgwalk_pkg;

    // Walk controller states
    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_RD_DIR,
        WALK_RD_TBL,
        WALK_DONE,
        WALK_FAULT
    } walk_state_t;

    // Fault level codes reported on resp_fault_lvl
    localparam logic [1:0] LVL_NONE = 2'd0;
    localparam logic [1:0] LVL_DIR  = 2'd1;
    localparam logic [1:0] LVL_TBL  = 2'd2;

endpackage

// File: rtl/pgwalk_base_reg.sv
// Directory base frame register.
// Holds the frame number (upper address bits) of the page directory.
// Assumes a page-aligned directory; the offset bits are never stored.
module pgwalk_base_reg #(
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [FRAME_W-1:0] wdata,
    output logic [FRAME_W-1:0] frame_q
);

    // Load a new base frame on a write strobe; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (we) begin
            frame_q <= wdata;
        end
    end

endmodule

// File: rtl/pgwalk_index_gen.sv
// Address formation for the walker.
// Builds the directory entry address, the table entry address and the
// final physical address from frames and address fields. Purely
// combinational. Assumes each entry is 2**ENT_LSB bytes wide, with
// ENT_LSB = OFF_W - IDX_W, so that one table fills exactly one page.
module pgwalk_index_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [IDX_W-1:0]        dir_idx,
    input  logic [ADDR_W-OFF_W-1:0] entry_frame,
    input  logic [IDX_W-1:0]        tbl_idx,
    input  logic [OFF_W-1:0]        offset,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       tbl_addr,
    output logic [ADDR_W-1:0]       phys_addr
);

    localparam int ENT_LSB = OFF_W - IDX_W;

    generate
        if (ENT_LSB > 0) begin : g_pad
            // Entry addresses: frame, index, then zero byte-lane bits
            always_comb begin
                dir_addr = {base_frame,  dir_idx, {ENT_LSB{1'b0}}};
                tbl_addr = {entry_frame, tbl_idx, {ENT_LSB{1'b0}}};
            end
        end else begin : g_nopad
            // Entry addresses when entries are one byte wide
            always_comb begin
                dir_addr = {base_frame,  dir_idx};
                tbl_addr = {entry_frame, tbl_idx};
            end
        end
    endgenerate

    // Physical address: table entry frame joined with untouched offset
    always_comb begin
        phys_addr = {entry_frame, offset};
    end

endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk controller.
// Sequences idle, directory read, table read and the one-cycle done or
// fault response. Holds the read request until memory returns data.
// Assumes the memory port answers each raised mem_rd_en with exactly one
// mem_rd_valid pulse, no earlier than the cycle after the request.
module pgwalk_ctrl
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    localparam int LO_W  = OFF_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lin,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [ADDR_W-1:0] phys_next,
    input  logic              mem_rd_valid,
    input  logic              entry_present,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [LO_W-1:0]   lin_lo_q,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_phys,
    output logic              resp_fault,
    output logic [1:0]        resp_fault_lvl
);

    walk_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] phys_q;
    logic [1:0]        lvl_q;
    logic              accept;

    assign accept = req_valid && (state_q == WALK_IDLE);

    // Next-state selection for the walk
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WALK_IDLE: begin
                if (req_valid) begin
                    state_d = paging_en ? WALK_RD_DIR : WALK_DONE;
                end
            end
            WALK_RD_DIR: begin
                if (mem_rd_valid) begin
                    state_d = entry_present ? WALK_RD_TBL : WALK_FAULT;
                end
            end
            WALK_RD_TBL: begin
                if (mem_rd_valid) begin
                    state_d = entry_present ? WALK_DONE : WALK_FAULT;
                end
            end
            WALK_DONE:  state_d = WALK_IDLE;
            WALK_FAULT: state_d = WALK_IDLE;
            default:    state_d = WALK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture: low address bits and the first entry address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_lo_q <= '0;
        end else if (accept) begin
            lin_lo_q <= req_lin[LO_W-1:0];
        end
    end

    // Read address register: directory entry, then table entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept && paging_en) begin
            addr_q <= dir_addr;
        end else if (state_q == WALK_RD_DIR && mem_rd_valid && entry_present) begin
            addr_q <= tbl_addr;
        end
    end

    // Result register: bypass address or translated address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_q <= '0;
        end else if (accept && !paging_en) begin
            phys_q <= req_lin;
        end else if (state_q == WALK_RD_TBL && mem_rd_valid && entry_present) begin
            phys_q <= phys_next;
        end
    end

    // Fault level register: records where a walk stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_NONE;
        end else if (accept) begin
            lvl_q <= LVL_NONE;
        end else if (mem_rd_valid && !entry_present) begin
            if (state_q == WALK_RD_DIR) begin
                lvl_q <= LVL_DIR;
            end else if (state_q == WALK_RD_TBL) begin
                lvl_q <= LVL_TBL;
            end
        end
    end

    // Output decode from the registered state
    always_comb begin
        req_ready      = (state_q == WALK_IDLE);
        mem_rd_en      = (state_q == WALK_RD_DIR) || (state_q == WALK_RD_TBL);
        mem_rd_addr    = addr_q;
        resp_valid     = (state_q == WALK_DONE) || (state_q == WALK_FAULT);
        resp_fault     = (state_q == WALK_FAULT);
        resp_phys      = (state_q == WALK_DONE) ? phys_q : '0;
        resp_fault_lvl = (state_q == WALK_FAULT) ? lvl_q : LVL_NONE;
    end

endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker, top level.
// Splits a linear address into directory index, table index and page
// offset, fetches two dependent entries over a single read port and
// returns a physical address or a present-bit fault with its level.
// Assumes ADDR_W = OFF_W + 2*IDX_W and that bit PRESENT_BIT of an entry
// is its present flag.
module pgwalk_top #(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int PRESENT_BIT = 0,
    localparam int FRAME_W    = ADDR_W - OFF_W,
    localparam int LO_W       = OFF_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               paging_en,
    input  logic               base_we,
    input  logic [FRAME_W-1:0] base_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_lin,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [ADDR_W-1:0]  mem_rd_data,
    output logic               resp_valid,
    output logic [ADDR_W-1:0]  resp_phys,
    output logic               resp_fault,
    output logic [1:0]         resp_fault_lvl
);

    logic [FRAME_W-1:0] base_frame;
    logic [ADDR_W-1:0]  dir_addr;
    logic [ADDR_W-1:0]  tbl_addr;
    logic [ADDR_W-1:0]  phys_next;
    logic [LO_W-1:0]    lin_lo_q;
    logic               entry_present;
    logic               unused_entry_bits;

    assign entry_present     = mem_rd_data[PRESENT_BIT];
    assign unused_entry_bits = ^mem_rd_data[OFF_W-1:0];

    pgwalk_base_reg #(
        .FRAME_W (FRAME_W)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (base_we),
        .wdata   (base_wdata),
        .frame_q (base_frame)
    );

    pgwalk_index_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_idx (
        .base_frame  (base_frame),
        .dir_idx     (req_lin[ADDR_W-1 -: IDX_W]),
        .entry_frame (mem_rd_data[ADDR_W-1:OFF_W]),
        .tbl_idx     (lin_lo_q[LO_W-1:OFF_W]),
        .offset      (lin_lo_q[OFF_W-1:0]),
        .dir_addr    (dir_addr),
        .tbl_addr    (tbl_addr),
        .phys_addr   (phys_next)
    );

    pgwalk_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .paging_en      (paging_en),
        .req_valid      (req_valid),
        .req_lin        (req_lin),
        .req_ready      (req_ready),
        .dir_addr       (dir_addr),
        .tbl_addr       (tbl_addr),
        .phys_next      (phys_next),
        .mem_rd_valid   (mem_rd_valid),
        .entry_present  (entry_present),
        .mem_rd_en      (mem_rd_en),
        .mem_rd_addr    (mem_rd_addr),
        .lin_lo_q       (lin_lo_q),
        .resp_valid     (resp_valid),
        .resp_phys      (resp_phys),
        .resp_fault     (resp_fault),
        .resp_fault_lvl (resp_fault_lvl)
    );

endmodule

// File: rtl/pgwalk_chk.sv
// Protocol checker for the page table walker, bound into pgwalk_top.
// Observes ports and the directory base register only.
module pgwalk_chk #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    paging_en,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [ADDR_W-1:0]       req_lin,
    input logic [ADDR_W-OFF_W-1:0] base_frame,
    input logic                    mem_rd_en,
    input logic [ADDR_W-1:0]       mem_rd_addr,
    input logic                    mem_rd_valid,
    input logic                    resp_valid,
    input logic [ADDR_W-1:0]       resp_phys,
    input logic                    resp_fault,
    input logic [1:0]              resp_fault_lvl
);

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    // R3
    dir_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && paging_en) |=>
            (mem_rd_en
             && mem_rd_addr[ADDR_W-1:OFF_W] == $past(base_frame)
             && mem_rd_addr[OFF_W-1:OFF_W-IDX_W] == $past(req_lin[ADDR_W-1 -: IDX_W])
             && mem_rd_addr[OFF_W-IDX_W-1:0] == '0));

    // R8
    bypass_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
            (resp_valid && !resp_fault && !mem_rd_en && resp_phys == $past(req_lin)));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R6
    fault_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_fault_lvl == 2'd1 || resp_fault_lvl == 2'd2));

    // R5
    clean_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_fault_lvl == 2'd0));

endmodule

bind pgwalk_top pgwalk_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .paging_en      (paging_en),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_lin        (req_lin),
    .base_frame     (base_frame),
    .mem_rd_en      (mem_rd_en),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rd_valid   (mem_rd_valid),
    .resp_valid     (resp_valid),
    .resp_phys      (resp_phys),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl)
);

// File: tb/sim_pgwalk_top.sv
// Scoreboard bench for pgwalk_top: a reference model pushes expected
// reads and responses, a memory model and a monitor compare them.
module sim_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        paging_en;
    logic        base_we;
    logic [19:0] base_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_lin;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        resp_valid;
    logic [31:0] resp_phys;
    logic        resp_fault;
    logic [1:0]  resp_fault_lvl;

    always #5 clk = ~clk;

    pgwalk_top u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .paging_en      (paging_en),
        .base_we        (base_we),
        .base_wdata     (base_wdata),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_lin        (req_lin),
        .mem_rd_en      (mem_rd_en),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_data    (mem_rd_data),
        .resp_valid     (resp_valid),
        .resp_phys      (resp_phys),
        .resp_fault     (resp_fault),
        .resp_fault_lvl (resp_fault_lvl)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [logic [31:0]];
    int          lat      = 1;
    int          cnt      = 0;
    int          rd_count = 0;
    logic [19:0] base_m   = 20'h0;

    logic [31:0] ea_q[$];
    string       ea_tag[$];
    logic [31:0] ph_q[$];
    logic        flt_q[$];
    logic [1:0]  lvl_q[$];
    string       tg_q[$];
    logic        prev_resp = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] dir_ea(input logic [19:0] b, input logic [31:0] lin);
        return {b, lin[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] tbl_ea(input logic [31:0] pde, input logic [31:0] lin);
        return {pde[31:12], lin[21:12], 2'b00};
    endfunction

    // Memory model: checks every waiting cycle's address, answers after lat cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_valid = 1'b0;
            cnt = 0;
        end else if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
        end else if (mem_rd_en) begin
            if (ea_q.size() > 0)
                chk(mem_rd_addr == ea_q[0], ea_tag[0], "read address", mem_rd_addr, ea_q[0]);
            else
                chk(1'b0, "R2", "unexpected read", mem_rd_addr, 32'h0);
            cnt++;
            if (cnt >= lat) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = rdm(mem_rd_addr);
                cnt = 0;
                rd_count++;
                if (ea_q.size() > 0) begin
                    void'(ea_q.pop_front());
                    void'(ea_tag.pop_front());
                end
            end
        end else begin
            cnt = 0;
        end
    end

    // Monitor: pops expected responses and checks the pulse rule
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_resp)
                chk(!resp_valid && req_ready, "R11", "pulse then ready",
                    {30'h0, resp_valid, req_ready}, 32'h1);
            prev_resp = resp_valid;
            if (resp_valid) begin
                if (ph_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected response", resp_phys, 32'h0);
                end else begin
                    chk(resp_fault == flt_q[0] && resp_fault_lvl == lvl_q[0], tg_q[0],
                        "fault/level", {29'h0, resp_fault, resp_fault_lvl},
                        {29'h0, flt_q[0], lvl_q[0]});
                    if (!flt_q[0])
                        chk(resp_phys == ph_q[0], tg_q[0], "physical address",
                            resp_phys, ph_q[0]);
                    void'(ph_q.pop_front());
                    void'(flt_q.pop_front());
                    void'(lvl_q.pop_front());
                    void'(tg_q.pop_front());
                end
            end
        end
    end

    // Reference model: pushes expected reads and the expected response
    task automatic expect_walk(input logic [31:0] lin, input string tag);
        logic [31:0] pde, pte, a1, a2;
        if (!paging_en) begin
            ph_q.push_back(lin); flt_q.push_back(1'b0); lvl_q.push_back(2'd0); tg_q.push_back(tag);
        end else begin
            a1 = dir_ea(base_m, lin);
            ea_q.push_back(a1); ea_tag.push_back("R3");
            pde = rdm(a1);
            if (!pde[0]) begin
                ph_q.push_back(32'h0); flt_q.push_back(1'b1); lvl_q.push_back(2'd1); tg_q.push_back(tag);
            end else begin
                a2 = tbl_ea(pde, lin);
                ea_q.push_back(a2); ea_tag.push_back("R4");
                pte = rdm(a2);
                if (!pte[0]) begin
                    ph_q.push_back(32'h0); flt_q.push_back(1'b1); lvl_q.push_back(2'd2); tg_q.push_back(tag);
                end else begin
                    ph_q.push_back({pte[31:12], lin[11:0]});
                    flt_q.push_back(1'b0); lvl_q.push_back(2'd0); tg_q.push_back(tag);
                end
            end
        end
    endtask

    // Driver: present a request until it is accepted
    task automatic issue(input logic [31:0] lin);
        @(negedge clk);
        req_valid = 1'b1;
        req_lin   = lin;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (ph_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic walk(input logic [31:0] lin, input string tag);
        expect_walk(lin, tag);
        issue(lin);
        drain();
    endtask

    task automatic write_base(input logic [19:0] f);
        @(negedge clk);
        base_we    = 1'b1;
        base_wdata = f;
        @(negedge clk);
        base_we    = 1'b0;
        base_m     = f;
    endtask

    task automatic set_pde(input logic [31:0] lin, input logic [19:0] fr, input bit p);
        mem[dir_ea(base_m, lin)] = {fr, 11'h0, p};
    endtask

    task automatic set_pte(input logic [19:0] tfr, input logic [31:0] lin,
                           input logic [19:0] fr, input bit p);
        mem[{tfr, lin[21:12], 2'b00}] = {fr, 11'h0, p};
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Test sequence
    initial begin
        int r0;
        rst_n = 1'b0; paging_en = 1'b1; base_we = 1'b0; base_wdata = '0;
        req_valid = 1'b0; req_lin = '0; mem_rd_valid = 1'b0; mem_rd_data = '0;
        repeat (3) @(negedge clk);
        // R1: in reset
        chk(req_ready && !resp_valid && !mem_rd_en, "R1", "reset outputs",
            {29'h0, req_ready, resp_valid, mem_rd_en}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: after release
        chk(req_ready && !resp_valid && !mem_rd_en, "R1", "after release",
            {29'h0, req_ready, resp_valid, mem_rd_en}, 32'h4);

        write_base(20'h00010);
        set_pde(32'h0040_3ABC, 20'h00020, 1'b1);
        set_pte(20'h00020, 32'h0040_3ABC, 20'hABCD0, 1'b1);
        set_pde(32'hFFC0_0FFF, 20'h00021, 1'b1);
        set_pte(20'h00021, 32'hFFC0_0FFF, 20'h12345, 1'b1);
        set_pde(32'h0000_1000, 20'h00022, 1'b1);
        set_pte(20'h00022, 32'h0000_1000, 20'h00777, 1'b1);
        set_pde(32'h0080_0000, 20'h00030, 1'b0);
        set_pde(32'h00C0_5123, 20'h00031, 1'b1);
        set_pte(20'h00031, 32'h00C0_5123, 20'h55555, 1'b0);

        // R5: translation with one-cycle memory
        walk(32'h0040_3ABC, "R5");
        // R10: longer latency, extreme indices
        lat = 4;
        walk(32'hFFC0_0FFF, "R10");
        walk(32'h0000_1000, "R5");

        // R6: directory entry not present, single read
        r0 = rd_count;
        walk(32'h0080_0000, "R6");
        chk(rd_count - r0 == 1, "R6", "read count", rd_count - r0, 1);
        // R6: directory entry never written (reads as zero)
        walk(32'h1234_5678, "R6");

        // R7: table entry not present, two reads
        r0 = rd_count;
        walk(32'h00C0_5123, "R7");
        chk(rd_count - r0 == 2, "R7", "read count", rd_count - r0, 2);

        // R8: paging disabled, answer next cycle without reads
        paging_en = 1'b0;
        r0 = rd_count;
        expect_walk(32'hDEAD_BEEF, "R8");
        @(negedge clk);
        req_valid = 1'b1; req_lin = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid && resp_phys == 32'hDEAD_BEEF, "R8", "bypass next cycle",
            resp_phys, 32'hDEAD_BEEF);
        drain();
        chk(rd_count == r0, "R8", "no reads in bypass", rd_count - r0, 0);
        paging_en = 1'b1;

        // R2: requests during a walk are ignored
        lat = 6;
        expect_walk(32'h0040_3ABC, "R2");
        issue(32'h0040_3ABC);
        for (int i = 0; i < 4; i++) begin
            req_valid = 1'b1; req_lin = 32'h0080_0000;
            chk(!req_ready, "R2", "busy ready", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        drain();
        repeat (5) @(negedge clk);

        // R9: base written mid-walk does not affect the current walk
        expect_walk(32'hFFC0_0FFF, "R9");
        issue(32'hFFC0_0FFF);
        write_base(20'h00050);
        drain();
        // R9: the next walk uses the new base
        lat = 2;
        set_pde(32'h0040_3ABC, 20'h00060, 1'b1);
        set_pte(20'h00060, 32'h0040_3ABC, 20'h0BEEF, 1'b1);
        walk(32'h0040_3ABC, "R9");

        repeat (3) @(negedge clk);
        chk(ea_q.size() == 0, "R4", "all expected reads seen", ea_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule